// File: doc/BRIEF.md
# DS3/E3 Transmit Alarm Signal Inserter

This block sits on the serial transmit path between a DS3/E3 framer and the line coder. While an alarm indication signal (AIS) is requested, it replaces the outgoing bit stream with one of two patterns. The first is an unframed all-ones stream, which works in every mode. The second is a fully framed DS3 alarm frame, which is allowed only in DS3 mode. Each clock carries one bit. The framer supplies a strobe on the first bit of every M-frame, and the block keeps its own position inside the 4760-bit M-frame, built as 7 subframes of 8 blocks of 85 bits, each block opening with one overhead bit.

Software turns the alarm on with an enable bit, and diagnostic loopback turns it on by itself. Switching on and off waits for an M-frame boundary, so the far end never sees a partial frame. Line loopback cuts the alarm off at once. After a framed alarm has started, the block runs its own frame counter and ignores later strobes, so a change of framer alignment cannot disturb the far end. In overhead-mask mode, a masked bit passes the framer's bit through and freezes the framed pattern generator for that cycle.

Top module: `ds3_tx_ais_inserter`

## Requirements
- R1: After reset no alarm is active, `ais_type_o` is 0, and `tx_data_o` equals `tx_data_i` on every bit.
- R2: An alarm is requested while `sw_ais_en_i` or `dlb_active_i` is 1. While `llb_active_i` is 1, the output is the input stream and `ais_type_o` is 0 on that same bit, whatever the request.
- R3: A change of alarm type, including turning it on or off, takes effect only on the first bit of an M-frame. Line loopback is the only exception. That first bit is the bit flagged by `mframe_start_i` when not locked, or the bit where the internal counter wraps.
- R4: While the unframed alarm is active, every output bit is 1, overhead and masked bits included.
- R5: `mode_i` encodes 0 = DS3, 1 = E3, 2 or 3 = clear channel. The framed alarm is chosen when `framed_sel_i` is 1 and mode is DS3. Every other request gives the unframed alarm.
- R6: In the framed alarm, bit k of each 85-bit block (k = 1..84) is 1 when k is odd and 0 when k is even. In every subframe, blocks 1 and 7 carry 1, block 3 and 5 carry 0, and blocks 2, 4 and 6 (C positions) carry 0. Block 0 carries 1 in subframes 0 and 1 (X), the parity value in subframes 2 and 3 (P), and 0,1,0 in subframes 4, 5 and 6 (M).
- R7: Both P bits equal the modulo-2 sum of the information bits (k = 1..84 of every block) emitted on `tx_data_o` in the preceding M-frame. Masked bits are excluded.
- R8: While the framed alarm is active, `mframe_start_i` is ignored and the frame position advances from its own counter.
- R9: When `ohm_mode_i` and `oh_mask_i` are both 1, the frame position and parity state hold for that bit. A framed alarm outputs `tx_data_i` on that bit.
- R10: `ais_type_o` reports the alarm on the current bit: 0 none, 1 unframed, 2 framed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data_i | input | 1 | Transmit bit from the framer |
| mframe_start_i | input | 1 | Marks the current bit as M-frame bit 0 |
| mode_i | input | 2 | Framing mode: 0 DS3, 1 E3, 2/3 clear channel |
| sw_ais_en_i | input | 1 | Software alarm request |
| framed_sel_i | input | 1 | 1 selects framed alarm (DS3 only) |
| dlb_active_i | input | 1 | Diagnostic loopback active, requests alarm |
| llb_active_i | input | 1 | Line loopback active, blocks alarm |
| ohm_mode_i | input | 1 | Overhead-mask mode enabled |
| oh_mask_i | input | 1 | Current bit is masked overhead |
| tx_data_o | output | 1 | Transmit bit after substitution |
| ais_type_o | output | 2 | Alarm on the current bit |

## Verification
Both outputs are combinational from the inputs and the registered state, so each result is due in the same cycle as its stimulus. A state change made at a rising edge first shows on the bit after that edge. A request that arrives in the middle of a frame shows only at the next frame's bit 0, and line loopback shows on the very bit where it rises. The bench drives every input one nanosecond after the rising edge. It compares both outputs with its behavioural model at the falling edge, then moves the model to the next bit, so stimulus and expected value always belong to the same bit.

// File: rtl/ais_gen_pkg.sv
package ais_gen_pkg;

    typedef enum logic [1:0] {
        AIS_NONE     = 2'd0,
        AIS_UNFRAMED = 2'd1,
        AIS_FRAMED   = 2'd2
    } ais_kind_e;

    localparam logic [1:0] MODE_DS3 = 2'd0;

    localparam int DS3_BLOCK_BITS = 85;
    localparam int DS3_BLOCKS     = 8;
    localparam int DS3_SUBFRAMES  = 7;

endpackage

// File: rtl/ais_frame_tracker.sv
module ais_frame_tracker #(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 8,
    parameter int SUBFRAMES  = 7,
    localparam int BW = $clog2(BLOCK_BITS),
    localparam int KW = $clog2(BLOCKS),
    localparam int SW = $clog2(SUBFRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic          adv_i,
    output logic [BW-1:0] bit_o,
    output logic [KW-1:0] blk_o,
    output logic [SW-1:0] sub_o,
    output logic          first_o
);

    typedef struct packed {
        logic [BW-1:0] bit_idx;
        logic [KW-1:0] blk;
        logic [SW-1:0] sub;
    } pos_t;

    localparam logic [BW-1:0] BIT_LAST = BW'(BLOCK_BITS - 1);
    localparam logic [KW-1:0] BLK_LAST = KW'(BLOCKS - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SUBFRAMES - 1);

    pos_t cur, pos_d, pos_q;

    always_comb begin
        cur   = sync_i ? '0 : pos_q;
        pos_d = cur;
        if (adv_i) begin
            if (cur.bit_idx == BIT_LAST) begin
                pos_d.bit_idx = '0;
                if (cur.blk == BLK_LAST) begin
                    pos_d.blk = '0;
                    pos_d.sub = (cur.sub == SUB_LAST) ? '0 : cur.sub + 1'b1;
                end else begin
                    pos_d.blk = cur.blk + 1'b1;
                end
            end else begin
                pos_d.bit_idx = cur.bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign bit_o   = cur.bit_idx;
    assign blk_o   = cur.blk;
    assign sub_o   = cur.sub;
    assign first_o = (cur == '0);

    // R9: a masked bit freezes the frame position
    p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !sync_i) |=> $stable(pos_q));

endmodule

// File: rtl/ais_ctrl.sv
module ais_ctrl
    import ais_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       first_i,
    input  logic       adv_i,
    input  logic       sw_en_i,
    input  logic       framed_sel_i,
    input  logic       dlb_i,
    input  logic       llb_i,
    input  logic [1:0] mode_i,
    output ais_kind_e  kind_o,
    output logic       locked_o
);

    typedef struct packed {
        ais_kind_e kind;
    } ctrl_t;

    ctrl_t st_d, st_q;
    ais_kind_e want;

    always_comb begin
        want = AIS_NONE;
        if (sw_en_i || dlb_i) begin
            want = (framed_sel_i && mode_i == MODE_DS3) ? AIS_FRAMED : AIS_UNFRAMED;
        end
        st_d = st_q;
        if (first_i && adv_i) st_d.kind = want;
        if (llb_i)            st_d.kind = AIS_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.kind <= AIS_NONE;
        else        st_q      <= st_d;
    end

    assign kind_o   = st_d.kind;
    assign locked_o = (st_q.kind == AIS_FRAMED);

    // R2: line loopback leaves no alarm behind
    p_llb_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        llb_i |=> (st_q.kind == AIS_NONE));

    // R3: alarm type moves only on an M-frame start bit or line loopback
    p_frame_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.kind) |-> ($past(first_i && adv_i) || $past(llb_i)));

    // R5: framed alarm is entered only in DS3 mode
    p_framed_ds3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.kind == AIS_FRAMED) |-> ($past(mode_i) == MODE_DS3));

endmodule

// File: rtl/ais_pattern_gen.sv
module ais_pattern_gen
    import ais_gen_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 8,
    parameter int SUBFRAMES  = 7,
    localparam int BW = $clog2(BLOCK_BITS),
    localparam int KW = $clog2(BLOCKS),
    localparam int SW = $clog2(SUBFRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bit_i,
    input  logic [KW-1:0] blk_i,
    input  logic [SW-1:0] sub_i,
    input  logic          first_i,
    input  logic          adv_i,
    input  ais_kind_e     kind_i,
    input  logic          data_i,
    output logic          data_o
);

    typedef struct packed {
        logic acc;
        logic par;
    } par_t;

    localparam logic [KW-1:0] BLK_LAST = KW'(BLOCKS - 1);

    par_t pr_d, pr_q;
    logic oh_bit;
    logic frame_bit;

    always_comb begin
        oh_bit = (bit_i == '0);
        if (!oh_bit) begin
            frame_bit = bit_i[0];
        end else if (blk_i == '0) begin
            if (sub_i < SW'(2))      frame_bit = 1'b1;
            else if (sub_i < SW'(4)) frame_bit = pr_q.par;
            else                     frame_bit = (sub_i == SW'(5));
        end else if (blk_i[0]) begin
            frame_bit = (blk_i == KW'(1)) || (blk_i == BLK_LAST);
        end else begin
            frame_bit = 1'b0;
        end

        case (kind_i)
            AIS_UNFRAMED: data_o = 1'b1;
            AIS_FRAMED:   data_o = adv_i ? frame_bit : data_i;
            default:      data_o = data_i;
        endcase

        pr_d = pr_q;
        if (adv_i) begin
            if (first_i) begin
                pr_d.par = pr_q.acc;
                pr_d.acc = 1'b0;
            end else if (!oh_bit) begin
                pr_d.acc = pr_q.acc ^ data_o;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    // R4: unframed alarm drives ones on every bit
    p_unframed_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == AIS_UNFRAMED) |-> data_o);

    // R9: a masked bit in framed alarm carries the framer's bit
    p_masked_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == AIS_FRAMED && !adv_i) |-> (data_o == data_i));

endmodule

// File: rtl/ds3_tx_ais_inserter.sv
module ds3_tx_ais_inserter
    import ais_gen_pkg::*;
#(
    parameter int BLOCK_BITS = DS3_BLOCK_BITS,
    parameter int BLOCKS     = DS3_BLOCKS,
    parameter int SUBFRAMES  = DS3_SUBFRAMES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_data_i,
    input  logic       mframe_start_i,
    input  logic [1:0] mode_i,
    input  logic       sw_ais_en_i,
    input  logic       framed_sel_i,
    input  logic       dlb_active_i,
    input  logic       llb_active_i,
    input  logic       ohm_mode_i,
    input  logic       oh_mask_i,
    output logic       tx_data_o,
    output logic [1:0] ais_type_o
);

    localparam int BW = $clog2(BLOCK_BITS);
    localparam int KW = $clog2(BLOCKS);
    localparam int SW = $clog2(SUBFRAMES);

    logic          adv;
    logic          locked;
    logic          first;
    logic [BW-1:0] bit_idx;
    logic [KW-1:0] blk_idx;
    logic [SW-1:0] sub_idx;
    ais_kind_e     kind;

    assign adv = !(ohm_mode_i && oh_mask_i);

    ais_frame_tracker #(
        .BLOCK_BITS (BLOCK_BITS),
        .BLOCKS     (BLOCKS),
        .SUBFRAMES  (SUBFRAMES)
    ) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (mframe_start_i && !locked),
        .adv_i   (adv),
        .bit_o   (bit_idx),
        .blk_o   (blk_idx),
        .sub_o   (sub_idx),
        .first_o (first)
    );

    ais_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .first_i      (first),
        .adv_i        (adv),
        .sw_en_i      (sw_ais_en_i),
        .framed_sel_i (framed_sel_i),
        .dlb_i        (dlb_active_i),
        .llb_i        (llb_active_i),
        .mode_i       (mode_i),
        .kind_o       (kind),
        .locked_o     (locked)
    );

    ais_pattern_gen #(
        .BLOCK_BITS (BLOCK_BITS),
        .BLOCKS     (BLOCKS),
        .SUBFRAMES  (SUBFRAMES)
    ) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (bit_idx),
        .blk_i   (blk_idx),
        .sub_i   (sub_idx),
        .first_i (first),
        .adv_i   (adv),
        .kind_i  (kind),
        .data_i  (tx_data_i),
        .data_o  (tx_data_o)
    );

    assign ais_type_o = kind;

endmodule

// File: tb/tb_ds3_tx_ais_inserter.sv
`timescale 1ns/1ps
module tb_ds3_tx_ais_inserter;

    localparam int FRAME = 4760;
    localparam int BLK   = 85;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_data_i = 1'b0;
    logic       mframe_start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       sw_ais_en_i = 1'b0;
    logic       framed_sel_i = 1'b0;
    logic       dlb_active_i = 1'b0;
    logic       llb_active_i = 1'b0;
    logic       ohm_mode_i = 1'b0;
    logic       oh_mask_i = 1'b0;
    logic       tx_data_o;
    logic [1:0] ais_type_o;

    always #4 clk = ~clk;

    ds3_tx_ais_inserter dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_data_i      (tx_data_i),
        .mframe_start_i (mframe_start_i),
        .mode_i         (mode_i),
        .sw_ais_en_i    (sw_ais_en_i),
        .framed_sel_i   (framed_sel_i),
        .dlb_active_i   (dlb_active_i),
        .llb_active_i   (llb_active_i),
        .ohm_mode_i     (ohm_mode_i),
        .oh_mask_i      (oh_mask_i),
        .tx_data_o      (tx_data_o),
        .ais_type_o     (ais_type_o)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string tag     = "R1";
    int    fpos    = 1;
    bit    rand_mask = 0;

    // reference model state
    int m_pos = 0, m_state = 0, m_acc = 0, m_par = 0;

    function automatic int framed_bit(int p, int par);
        int k, b, s;
        k = p % BLK;
        b = (p / BLK) % 8;
        s = p / (BLK * 8);
        if (k != 0)       return k % 2;
        if (b == 0) begin
            if (s < 2)    return 1;
            if (s < 4)    return par;
            return (s == 5) ? 1 : 0;
        end
        if (b == 1 || b == 7) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: got %0d expected %0d", req, $time, got, exp);
        end
    endtask

    // behavioural reference, compared on every bit at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_state = 0; m_acc = 0; m_par = 0;
        end else begin
            int adv, cur, want, eff, exp_d;
            adv  = !(ohm_mode_i && oh_mask_i);
            cur  = (mframe_start_i && m_state != 2) ? 0 : m_pos;
            want = 0;
            if (sw_ais_en_i || dlb_active_i)
                want = (framed_sel_i && mode_i == 2'd0) ? 2 : 1;
            eff = m_state;
            if (cur == 0 && adv) eff = want;
            if (llb_active_i) eff = 0;
            if (eff == 1)                exp_d = 1;
            else if (eff == 2 && adv)    exp_d = framed_bit(cur, m_par);
            else                         exp_d = tx_data_i;
            check(tx_data_o == exp_d[0], tag, tx_data_o, exp_d);
            check(ais_type_o == eff[1:0], {tag, "/R10"}, ais_type_o, eff);
            if (adv) begin
                if (cur == 0) begin m_par = m_acc; m_acc = 0; end
                else if (cur % BLK != 0) m_acc = m_acc ^ exp_d;
                m_pos = (cur + 1) % FRAME;
            end else begin
                m_pos = cur;
            end
            m_state = eff;
        end
    end

    // one bit of framer stimulus, applied just after the rising edge
    task automatic tick();
        @(posedge clk);
        #1;
        if (!(ohm_mode_i && oh_mask_i)) fpos = (fpos + 1) % FRAME;
        mframe_start_i = (fpos == 0);
        tx_data_i      = 1'($urandom);
        oh_mask_i      = rand_mask ? (($urandom % 8) == 0) : 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(190000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        tx_data_i = 1'b1;
        #2;
        check(ais_type_o == 2'd0, "R1", ais_type_o, 0);
        check(tx_data_o == 1'b1, "R1", tx_data_o, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        tag = "R1";
        run(FRAME);

        // R3/R4: unframed alarm requested mid-frame, DS3 mode
        while (fpos != 2000) tick();
        tag = "R3/R4";
        sw_ais_en_i = 1'b1;
        run(10);
        @(negedge clk);
        check(ais_type_o == 2'd0, "R3", ais_type_o, 0);
        run(2 * FRAME);
        @(negedge clk);
        check(ais_type_o == 2'd1, "R4", ais_type_o, 1);

        // R3: turn off mid-frame, waits for boundary
        sw_ais_en_i = 1'b0;
        run(20);
        @(negedge clk);
        check(ais_type_o == 2'd1, "R3", ais_type_o, 1);
        run(FRAME);

        // R6/R7: framed alarm, several frames
        tag = "R6/R7";
        sw_ais_en_i  = 1'b1;
        framed_sel_i = 1'b1;
        run(3 * FRAME);
        @(negedge clk);
        check(ais_type_o == 2'd2, "R6", ais_type_o, 2);

        // R8: framer moves its alignment while framed alarm runs
        tag = "R8";
        @(posedge clk); #1;
        fpos = (fpos + 1000) % FRAME;
        run(FRAME + 300);
        @(negedge clk);
        check(ais_type_o == 2'd2, "R8", ais_type_o, 2);

        // R5: framed request in E3 and clear-channel modes gives unframed
        tag = "R5";
        mode_i = 2'd1;
        run(2 * FRAME);
        @(negedge clk);
        check(ais_type_o == 2'd1, "R5", ais_type_o, 1);
        mode_i = 2'd3;
        run(FRAME);
        @(negedge clk);
        check(ais_type_o == 2'd1, "R5", ais_type_o, 1);

        // R2: diagnostic loopback requests, line loopback blocks at once
        tag = "R2";
        mode_i       = 2'd2;
        framed_sel_i = 1'b0;
        sw_ais_en_i  = 1'b0;
        dlb_active_i = 1'b1;
        run(2 * FRAME);
        @(negedge clk);
        check(ais_type_o == 2'd1, "R2", ais_type_o, 1);
        @(posedge clk); #1;
        llb_active_i = 1'b1;
        @(negedge clk);
        check(ais_type_o == 2'd0, "R2", ais_type_o, 0);
        check(tx_data_o == tx_data_i, "R2", tx_data_o, tx_data_i);
        run(FRAME);
        llb_active_i = 1'b0;
        run(FRAME);

        // R9: overhead mask pauses framed alarm
        tag = "R9/R7";
        dlb_active_i = 1'b0;
        mode_i       = 2'd0;
        sw_ais_en_i  = 1'b1;
        framed_sel_i = 1'b1;
        ohm_mode_i   = 1'b1;
        rand_mask    = 1'b1;
        run(3 * FRAME);
        @(negedge clk);
        check(ais_type_o == 2'd2, "R9", ais_type_o, 2);

        // R4: unframed with masking still all ones
        tag = "R4/R9";
        framed_sel_i = 1'b0;
        run(2 * FRAME);

        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule